// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block steps a clock-generator PLL from one set of divider values to another without ever letting a half-configured PLL drive the clock tree. A request carries four divider values: the reference divider, the output divider, the feedback divider and the bandwidth divider. While idle the block accepts one request. If the output-mode mux is currently selecting the PLL output, the block first forces the mux onto the slow reference clock. It then holds the PLL in reset, loads the divider fields and releases reset.

After reset is released, the block waits a settle time that grows with the reference divider. It then samples the lock input for a bounded number of cycles. If lock never arrives, the block runs the whole reset-and-load pass once more with the divider fields it saw before the request, so the PLL falls back to its last good setting. At the end, the mux goes back to normal mode only if the block itself moved it away from normal. A single-cycle done pulse then reports the result, together with an error bit.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, pll_rst, busy, done and err are 0, every divider field holds its reset parameter (0 by default), and mode_sel equals mode_in.
- R2: When mode_in is normal (code 1) at the time a request is accepted, mode_sel reads slow (code 0) from the cycle after acceptance until done. In the done cycle mode_sel equals mode_in again. When mode_in is slow (0) or deep (2), mode_sel equals mode_in throughout.
- R3: pll_rst rises before any divider field changes. The fields change only while pll_rst is high, and pll_rst falls after the load.
- R4: Each divider field is driven as the requested value minus one (requested N gives field N-1).
- R5: After pll_rst falls, the block ignores lock for C = ((NR*500)/24 + 1) * CYC_PER_US cycles, where NR is the requested reference divider. With lock held high, done is seen exactly C+2 cycles after the first cycle in which pll_rst reads low.
- R6: If lock stays low for LOCK_POLL_MAX consecutive samples, the block pulses pll_rst again and reloads the divider fields that were present before the request.
- R7: Any lock timeout makes err 1 at done, whether or not the rollback pass then locks. After a rollback the fields show the pre-request values.
- R8: done is high for exactly one cycle per accepted request. err is 0 when lock was seen on the first pass.
- R9: A request presented while busy is 1 is ignored. The divider fields end up with the values of the request that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_nr | input | NR_W+1 | Requested reference divider (N, not N-1) |
| req_no | input | NO_W+1 | Requested output divider |
| req_nf | input | NF_W+1 | Requested feedback divider |
| req_nb | input | NB_W+1 | Requested bandwidth divider |
| mode_in | input | 2 | Current mux mode: 0 slow, 1 normal, 2 deep |
| lock | input | 1 | PLL lock status |
| mode_sel | output | 2 | Mux mode actually applied |
| pll_rst | output | 1 | PLL reset, active high |
| fld_nr | output | NR_W | Reference divider field (N-1) |
| fld_no | output | NO_W | Output divider field (N-1) |
| fld_nf | output | NF_W | Feedback divider field (N-1) |
| fld_nb | output | NB_W | Bandwidth divider field (N-1) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Result of the last sequence: 1 means a lock timeout occurred |

## Verification
The bench builds the block with CYC_PER_US = 2 and LOCK_POLL_MAX = 16, and keeps the default divider widths. With these values the settle window for reference dividers 1 and 5 is 42 and 210 cycles, so its exact length can be counted cycle by cycle. The 16-sample lock window keeps both the double-failure path and the path where the rollback pass locks short enough to run many times. Because the default widths are kept, the field arithmetic is exercised at full size.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
   typedef enum logic [1:0] {
      MODE_SLOW = 2'd0,
      MODE_NORM = 2'd1,
      MODE_DEEP = 2'd2
   } mux_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST_ON,
      ST_LOAD,
      ST_REL,
      ST_SETTLE,
      ST_POLL,
      ST_FIN
   } seq_state_e;

   localparam int US_NUM = 500;
   localparam int US_DEN = 24;
endpackage

// File: rtl/pll_seq_settle_calc.sv
module pll_seq_settle_calc #(
   parameter int NR_W       = 6,
   parameter int CYC_PER_US = 24,
   parameter int SET_W      = 16
) (
   input  logic [NR_W-1:0]  nr_field,
   output logic [SET_W-1:0] settle_m1
);
   import pll_seq_pkg::*;
   int nr_val;
   int us;
   int cyc;
   always_comb begin
      nr_val    = int'(nr_field) + 1;
      us        = (nr_val * US_NUM) / US_DEN + 1;
      cyc       = us * CYC_PER_US;
      settle_m1 = SET_W'(cyc - 1);
   end
endmodule

// File: rtl/pll_seq_down_cnt.sv
module pll_seq_down_cnt #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic             dec,
   output logic             zero
);
   logic [WIDTH-1:0] cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (load)               cnt <= load_val;
      else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
   end
   assign zero = (cnt == '0);

   a_r6_cnt_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && $past(cnt) == '0 && !$past(load)) |-> cnt == '0)
      else $error("counter wrapped below zero");
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
   parameter int NR_W          = 6,
   parameter int NO_W          = 4,
   parameter int NF_W          = 13,
   parameter int NB_W          = 12,
   parameter int CYC_PER_US    = 24,
   parameter int LOCK_POLL_MAX = 24000000,
   parameter logic [NR_W-1:0] RST_NR = '0,
   parameter logic [NO_W-1:0] RST_NO = '0,
   parameter logic [NF_W-1:0] RST_NF = '0,
   parameter logic [NB_W-1:0] RST_NB = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [NR_W:0]   req_nr,
   input  logic [NO_W:0]   req_no,
   input  logic [NF_W:0]   req_nf,
   input  logic [NB_W:0]   req_nb,
   input  logic [1:0]      mode_in,
   input  logic            lock,
   output logic [1:0]      mode_sel,
   output logic            pll_rst,
   output logic [NR_W-1:0] fld_nr,
   output logic [NO_W-1:0] fld_no,
   output logic [NF_W-1:0] fld_nf,
   output logic [NB_W-1:0] fld_nb,
   output logic            busy,
   output logic            done,
   output logic            err
);
   import pll_seq_pkg::*;

   localparam int MAX_US  = ((2 ** NR_W) * US_NUM) / US_DEN + 1;
   localparam int MAX_CYC = MAX_US * CYC_PER_US;
   localparam int SET_W   = $clog2(MAX_CYC + 1);
   localparam int POLL_W  = $clog2(LOCK_POLL_MAX + 1);
   localparam int ALL_W   = NR_W + NO_W + NF_W + NB_W;

   generate
      if (CYC_PER_US < 1) begin : g_bad_cyc
         $error("CYC_PER_US must be at least 1");
      end
      if (LOCK_POLL_MAX < 1) begin : g_bad_poll
         $error("LOCK_POLL_MAX must be at least 1");
      end
      if (NR_W < 1 || NO_W < 1 || NF_W < 1 || NB_W < 1) begin : g_bad_w
         $error("divider widths must be positive");
      end
   endgenerate

   seq_state_e       st;
   logic [ALL_W-1:0] pend, bak, fld_all;
   logic             parked, retry, fail;
   logic [SET_W-1:0] settle_m1;
   logic             settle_zero, poll_zero;
   logic             settle_load, settle_dec, poll_load, poll_dec;

   assign fld_all = {fld_nr, fld_no, fld_nf, fld_nb};

   pll_seq_settle_calc #(.NR_W(NR_W), .CYC_PER_US(CYC_PER_US), .SET_W(SET_W)) u_calc (
      .nr_field (pend[ALL_W-1 -: NR_W]),
      .settle_m1(settle_m1)
   );

   assign settle_load = (st == ST_REL);
   assign settle_dec  = (st == ST_SETTLE);
   assign poll_load   = (st == ST_SETTLE) && settle_zero;
   assign poll_dec    = (st == ST_POLL) && !lock;

   pll_seq_down_cnt #(.WIDTH(SET_W)) u_settle (
      .clk(clk), .rst_n(rst_n), .load(settle_load), .load_val(settle_m1),
      .dec(settle_dec), .zero(settle_zero)
   );

   pll_seq_down_cnt #(.WIDTH(POLL_W)) u_poll (
      .clk(clk), .rst_n(rst_n), .load(poll_load),
      .load_val(POLL_W'(LOCK_POLL_MAX - 1)), .dec(poll_dec), .zero(poll_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         pend    <= '0;
         bak     <= '0;
         {fld_nr, fld_no, fld_nf, fld_nb} <= {RST_NR, RST_NO, RST_NF, RST_NB};
         parked  <= 1'b0;
         retry   <= 1'b0;
         fail    <= 1'b0;
         pll_rst <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (req_valid) begin
               pend   <= {NR_W'(req_nr - 1'b1), NO_W'(req_no - 1'b1),
                          NF_W'(req_nf - 1'b1), NB_W'(req_nb - 1'b1)};
               bak    <= fld_all;
               parked <= (mode_in == MODE_NORM);
               retry  <= 1'b0;
               fail   <= 1'b0;
               st     <= ST_RST_ON;
            end
            ST_RST_ON: begin
               pll_rst <= 1'b1;
               st      <= ST_LOAD;
            end
            ST_LOAD: begin
               {fld_nr, fld_no, fld_nf, fld_nb} <= pend;
               st <= ST_REL;
            end
            ST_REL: begin
               pll_rst <= 1'b0;
               st      <= ST_SETTLE;
            end
            ST_SETTLE: if (settle_zero) st <= ST_POLL;
            ST_POLL: begin
               if (lock) begin
                  st <= ST_FIN;
               end else if (poll_zero) begin
                  fail <= 1'b1;
                  if (!retry) begin
                     retry <= 1'b1;
                     pend  <= bak;
                     st    <= ST_RST_ON;
                  end else begin
                     st <= ST_FIN;
                  end
               end
            end
            ST_FIN: begin
               done   <= 1'b1;
               err    <= fail;
               parked <= 1'b0;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st != ST_IDLE);
   assign mode_sel = parked ? MODE_SLOW : mode_in;

   a_r3_fields_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (fld_all != $past(fld_all)) |-> (pll_rst && $past(pll_rst)))
      else $error("divider field changed outside reset window");

   a_r5_no_reset_in_settle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SETTLE || st == ST_POLL) |-> !pll_rst)
      else $error("reset held during settle or poll");

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle");

   a_r2_restore_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(parked) |-> done)
      else $error("mux restored without done");

   a_r9_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
      (done) |-> !busy)
      else $error("done while still busy");
endmodule

// File: tb/pll_reprog_seq_bench.sv
module pll_reprog_seq_bench;
   localparam int NR_W = 6, NO_W = 4, NF_W = 13, NB_W = 12;
   localparam int CPU = 2, PMAX = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [NR_W:0] req_nr = '0;
   logic [NO_W:0] req_no = '0;
   logic [NF_W:0] req_nf = '0;
   logic [NB_W:0] req_nb = '0;
   logic [1:0] mode_in = 2'd0;
   logic lock = 1'b0;
   logic [1:0] mode_sel;
   logic pll_rst, busy, done, err;
   logic [NR_W-1:0] fld_nr;
   logic [NO_W-1:0] fld_no;
   logic [NF_W-1:0] fld_nf;
   logic [NB_W-1:0] fld_nb;

   always #2 clk = ~clk;

   pll_reprog_seq #(.NR_W(NR_W), .NO_W(NO_W), .NF_W(NF_W), .NB_W(NB_W),
                    .CYC_PER_US(CPU), .LOCK_POLL_MAX(PMAX)) u_pll_reprog_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_nr(req_nr),
      .req_no(req_no), .req_nf(req_nf), .req_nb(req_nb), .mode_in(mode_in),
      .lock(lock), .mode_sel(mode_sel), .pll_rst(pll_rst), .fld_nr(fld_nr),
      .fld_no(fld_no), .fld_nf(fld_nf), .fld_nb(fld_nb), .busy(busy),
      .done(done), .err(err));

   int n_chk = 0, n_bad = 0;
   int rises, since_fall, mode_bad;
   logic [31:0] fld_at_rise;
   logic timed_out;

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pack_f();
      return {fld_nr, fld_no, fld_nf, fld_nb} & 32'hFFFF_FFFF;
   endfunction

   function automatic int settle_cyc(input int nr);
      return ((nr * 500) / 24 + 1) * CPU;
   endfunction

   // policy: 0 lock high, 1 lock low, 2 lock only from second reset pulse
   task automatic run_op(input logic [1:0] md, input int nr, input int no, input int nf,
                         input int nb, input int policy, input logic inject);
      @(negedge clk);
      mode_in = md;
      req_nr = (NR_W+1)'(nr); req_no = (NO_W+1)'(no);
      req_nf = (NF_W+1)'(nf); req_nb = (NB_W+1)'(nb);
      lock = (policy == 0);
      req_valid = 1'b1;
      rises = 0; since_fall = 0; mode_bad = 0; timed_out = 1'b1;
      fld_at_rise = '0;
      @(negedge clk);
      req_valid = 1'b0;
      begin
         logic prev = 1'b0;
         for (int k = 0; k < 20000; k++) begin
            if (inject && k == 3) begin
               req_valid = 1'b1; req_nr = 7'd9; req_no = 5'd9;
               req_nf = 14'd9; req_nb = 13'd9;
            end else begin
               req_valid = 1'b0;
            end
            if (pll_rst && !prev) begin
               rises++;
               if (rises == 1) fld_at_rise = pack_f();
            end
            if (!pll_rst && prev) since_fall = 0; else since_fall++;
            prev = pll_rst;
            if (mode_sel != ((md == 2'd1 && !done) ? 2'd0 : md)) mode_bad++;
            lock = (policy == 0) || (policy == 2 && rises >= 2);
            if (done) begin timed_out = 1'b0; break; end
            @(negedge clk);
         end
      end
      req_valid = 1'b0;
      check(!timed_out, "watchdog", 1, 0);
   endtask

   task automatic t_reset();
      check(pll_rst == 0 && busy == 0 && done == 0 && err == 0, "R1 ctrl outputs idle",
            {pll_rst, busy, done, err}, 0);
      check(pack_f() == 0, "R1 fields at reset value", pack_f(), 0);
      mode_in = 2'd1; #1;
      check(mode_sel == 2'd1, "R1 mode passthrough", mode_sel, 1);
   endtask

   task automatic t_load_ok();
      logic [31:0] old = pack_f();
      run_op(2'd1, 1, 2, 100, 50, 0, 1'b0);
      check(fld_nr == 0 && fld_no == 1, "R4 nr/no fields", {fld_nr, fld_no}, 1);
      check(fld_nf == 99 && fld_nb == 49, "R4 nf/nb fields", fld_nf, 99);
      check(since_fall == settle_cyc(1) + 2, "R5 settle nr=1", since_fall, settle_cyc(1) + 2);
      check(err == 0, "R8 err clear on lock", err, 0);
      check(mode_bad == 0, "R2 parked then restored", mode_bad, 0);
      check(rises == 1 && fld_at_rise == old, "R3 reset before load", rises, 1);
      @(negedge clk);
      check(done == 0, "R8 done one cycle", done, 0);
   endtask

   task automatic t_settle_nr5();
      run_op(2'd0, 5, 3, 40, 20, 0, 1'b0);
      check(since_fall == settle_cyc(5) + 2, "R5 settle nr=5", since_fall, settle_cyc(5) + 2);
      check(mode_bad == 0, "R2 slow untouched", mode_bad, 0);
      check(pll_rst == 0, "R3 reset released", pll_rst, 0);
   endtask

   task automatic t_deep();
      run_op(2'd2, 3, 4, 60, 30, 0, 1'b0);
      check(mode_bad == 0, "R2 deep untouched", mode_bad, 0);
      check(fld_nr == 2 && fld_nf == 59, "R4 fields deep run", fld_nf, 59);
   endtask

   task automatic t_rollback(input int policy, input string tag);
      logic [31:0] old = pack_f();
      run_op(2'd1, 7, 5, 200, 80, policy, 1'b0);
      check(rises == 2, {"R6 second reset pulse ", tag}, rises, 2);
      check(pack_f() == old, {"R7 fields rolled back ", tag}, pack_f(), old);
      check(err == 1, {"R7 err set ", tag}, err, 1);
      check(mode_bad == 0, {"R2 parked through rollback ", tag}, mode_bad, 0);
   endtask

   task automatic t_busy_ignore();
      run_op(2'd0, 2, 2, 10, 6, 0, 1'b1);
      check(fld_nr == 1 && fld_no == 1 && fld_nf == 9 && fld_nb == 5,
            "R9 request while busy ignored", fld_nf, 9);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_load_ok();
      t_settle_nr5();
      t_deep();
      t_rollback(1, "double fail");
      t_rollback(2, "retry locks");
      t_busy_ignore();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule